// File: doc/BRIEF.md
# Framing and Marker Pulse Generator

This block watches a high-band reference square wave and turns its falling edges into four slow counter-control signals. Two of them are framing waves: each holds high for a fixed number of reference falling edges, then low for the same number, and repeats. The other two are markers: each gives one positive pulse of fixed duration whenever its edge count completes. One framing wave and one marker work on a short span (247 edges by default), the other pair on a long span (2147 edges by default).

The reference comes from another clock domain, so it is brought into the system clock through a two-stage synchronizer, and a registered falling-edge detector produces a one-cycle event. Each span channel counts those events. Marker width is timed in system clock cycles (369 by default, about 20 µs at 18.432 MHz), so it does not depend on the reference rate. Downstream timers use the framing waves to start, stop and reset counting and the markers to tag each span boundary.

Top module: `frame_marker_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, both framing outputs are 1, both marker outputs are 0, and both edge counts are zero, so the first boundary of each span comes after exactly SHORT_EDGES or LONG_EDGES falling edges following reset.
- R2: Only a 1-to-0 transition of the reference advances the counts; rising edges and a steady reference leave every output unchanged.
- R3: The short framing output is 1 after n reference falling edges since reset when floor(n / SHORT_EDGES) is even and 0 otherwise, so it holds each level for SHORT_EDGES edges.
- R4: The long framing output follows the same rule with LONG_EDGES.
- R5: The short marker goes to 1 exactly when the falling-edge count reaches a multiple of SHORT_EDGES, in the same cycle that the short framing output toggles, and at no other falling edge.
- R6: The long marker follows the same rule with LONG_EDGES.
- R7: Each marker pulse lasts exactly MARK_CYCLES system clock cycles, whatever the reference period.
- R8: A reference falling edge applied just after clock edge P0 changes the framing and marker outputs after clock edge P3 (two synchronizer stages plus one detector register) and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | High-band reference square wave, asynchronous to clk_i |
| frame_short_o | output | 1 | Framing wave, SHORT_EDGES edges per level |
| frame_long_o | output | 1 | Framing wave, LONG_EDGES edges per level |
| mark_short_o | output | 1 | Marker pulse every SHORT_EDGES edges |
| mark_long_o | output | 1 | Marker pulse every LONG_EDGES edges |

## Verification
A reference fall driven just after one clock edge is due at the outputs after the third following edge, so the bench samples on the falling clock edge two edges later to confirm no early change and then one edge later for the new framing level and marker rise. Each marker is then sampled at the next MARK_CYCLES-1 falling clock edges to confirm it stays high and at one more to confirm it has dropped, which pins its width to the cycle. After the reference rises and is held, outputs are sampled again to confirm nothing moved, and the whole sweep is repeated at a second reference period with the span counts shrunk so every boundary is crossed several times.

// File: rtl/frame_marker_pkg.sv
package frame_marker_pkg;

  // Next value of an edge counter that spans 0 .. span-1.
  function automatic int unsigned span_next(input int unsigned cur, input int unsigned span);
    return (cur + 1 >= span) ? 0 : cur + 1;
  endfunction

  // True when the current count is the last one before the boundary.
  function automatic bit span_last(input int unsigned cur, input int unsigned span);
    return (cur + 1 >= span);
  endfunction

  // Bits needed to hold values 0 .. top.
  function automatic int unsigned bits_for(input int unsigned top);
    return (top < 2) ? 1 : $clog2(top + 1);
  endfunction

endpackage

// File: rtl/ref_fall_detect.sv
module ref_fall_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ref_i,
  output logic fall_o
);
  // two synchronizer stages plus one history register
  logic sync_a, sync_b, hist_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      sync_a <= ref_i;
      sync_b <= sync_a;
      hist_q <= sync_b;
    end
  end

  assign fall_o = hist_q & ~sync_b;

  // R2: a fall event lasts a single cycle
  a_r2_fall_single: assert property (@(posedge clk_i) disable iff (rst_i)
    fall_o |=> !fall_o);

endmodule

// File: rtl/marker_timer.sv
module marker_timer #(
  parameter int unsigned MARK_CYCLES = 369
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic pulse_o
);
  import frame_marker_pkg::*;
  localparam int unsigned MW = bits_for(MARK_CYCLES);

  logic [MW-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)          left_q <= '0;
    else if (start_i)   left_q <= MW'(MARK_CYCLES);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

  // R7: a started pulse is visible in the next cycle
  a_r7_start_seen: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |=> pulse_o);

  // R7: the pulse ends only after the last remaining cycle is spent
  a_r7_end_on_last: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(pulse_o) |-> ($past(left_q) == MW'(1)));

endmodule

// File: rtl/span_channel.sv
module span_channel #(
  parameter int unsigned EDGES       = 247,
  parameter int unsigned MARK_CYCLES = 369
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fall_i,
  output logic frame_o,
  output logic mark_o
);
  import frame_marker_pkg::*;
  localparam int unsigned CW = bits_for(EDGES - 1);

  logic [CW-1:0] count_q;
  logic          frame_q;
  logic          wrap_w;

  assign wrap_w = fall_i && span_last(int'(count_q), EDGES);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_q <= '0;
      frame_q <= 1'b1;
    end else if (fall_i) begin
      count_q <= CW'(span_next(int'(count_q), EDGES));
      if (wrap_w) frame_q <= ~frame_q;
    end
  end

  assign frame_o = frame_q;

  marker_timer #(.MARK_CYCLES(MARK_CYCLES)) mark_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (wrap_w),
    .pulse_o (mark_o)
  );

  // R3: the count stays inside its span
  a_r3_count_range: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(count_q) < EDGES);

  // R2: without a fall event the count holds
  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !fall_i |=> $stable(count_q));

  // R3: the frame level moves only on a span boundary
  a_r3_frame_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_w |=> $stable(frame_o));

  // R5: a boundary raises the marker together with a frame toggle
  a_r5_mark_with_toggle: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_w |=> (mark_o && (frame_o != $past(frame_o))));

endmodule

// File: rtl/frame_marker_gen.sv
module frame_marker_gen #(
  parameter int unsigned SHORT_EDGES = 247,
  parameter int unsigned LONG_EDGES  = 2147,
  parameter int unsigned MARK_CYCLES = 369
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ref_i,
  output logic frame_short_o,
  output logic frame_long_o,
  output logic mark_short_o,
  output logic mark_long_o
);
  localparam int unsigned NCH = 2;
  localparam int unsigned SPAN_TBL [NCH] = '{SHORT_EDGES, LONG_EDGES};

  logic           fall_w;
  logic [NCH-1:0] frame_w;
  logic [NCH-1:0] mark_w;

  ref_fall_detect det_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .ref_i  (ref_i),
    .fall_o (fall_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    span_channel #(
      .EDGES       (SPAN_TBL[g]),
      .MARK_CYCLES (MARK_CYCLES)
    ) chan_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .fall_i  (fall_w),
      .frame_o (frame_w[g]),
      .mark_o  (mark_w[g])
    );
  end

  assign frame_short_o = frame_w[0];
  assign frame_long_o  = frame_w[1];
  assign mark_short_o  = mark_w[0];
  assign mark_long_o   = mark_w[1];

  // R1: the cycle after reset shows the reset state
  a_r1_reset_state: assert property (@(posedge clk_i)
    $fell(rst_i) |-> (frame_short_o && frame_long_o && !mark_short_o && !mark_long_o));

  // R8: outputs never move without an input fall three edges earlier
  a_r8_no_spontaneous: assert property (@(posedge clk_i) disable iff (rst_i)
    !fall_w |=> ($stable(frame_short_o) && $stable(frame_long_o)));

endmodule

// File: tb/frame_marker_gen_tb_top.sv
module frame_marker_gen_tb_top;
  localparam int S = 3;
  localparam int L = 5;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refw = 1'b1;
  logic fs, fl, ms, ml;

  int checks = 0;
  int fails = 0;
  int nfall = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frame_marker_gen #(.SHORT_EDGES(S), .LONG_EDGES(L), .MARK_CYCLES(W)) dut_i (
    .clk_i(clk), .rst_i(rst), .ref_i(refw),
    .frame_short_o(fs), .frame_long_o(fl),
    .mark_short_o(ms), .mark_long_o(ml)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at fall %0d: actual=%b expected=%b", req, nfall, act, exp);
    end
  endtask

  function automatic logic frame_exp(input int n, input int span);
    return ((n / span) % 2) == 0;
  endfunction

  task automatic check_reset_state();
    check("R1 frame_short", fs, 1'b1);
    check("R1 frame_long", fl, 1'b1);
    check("R1 mark_short", ms, 1'b0);
    check("R1 mark_long", ml, 1'b0);
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); check_reset_state();
    #1 rst = 1'b0;
    @(posedge clk); @(negedge clk); check_reset_state();
    nfall = 0;
  endtask

  // One reference period: fall, hold low, rise, hold high.
  task automatic one_period(input int lo_extra, input int hi_cycles);
    logic old_s, old_l, ws, wl;
    old_s = frame_exp(nfall, S);
    old_l = frame_exp(nfall, L);
    @(posedge clk); #1 refw = 1'b0;
    nfall++;
    ws = (nfall % S) == 0;
    wl = (nfall % L) == 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 short frame not early", fs, old_s);
    check("R8 long frame not early", fl, old_l);
    check("R8 short mark not early", ms, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R3 short frame", fs, frame_exp(nfall, S));
    check("R4 long frame", fl, frame_exp(nfall, L));
    check("R5 short mark rise", ms, ws);
    check("R6 long mark rise", ml, wl);
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      check("R7 short mark held", ms, ws);
      check("R7 long mark held", ml, wl);
    end
    @(negedge clk);
    check("R7 short mark ended", ms, 1'b0);
    check("R7 long mark ended", ml, 1'b0);
    repeat (lo_extra) @(posedge clk);
    #1 refw = 1'b1;
    repeat (hi_cycles) @(posedge clk);
    @(negedge clk);
    check("R2 short frame after rise", fs, frame_exp(nfall, S));
    check("R2 long frame after rise", fl, frame_exp(nfall, L));
    check("R2 short mark after rise", ms, 1'b0);
    check("R2 long mark after rise", ml, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); check_reset_state();
    #1 rst = 1'b0;
    @(posedge clk); @(negedge clk); check_reset_state();
    // R2: steady high reference for a while changes nothing
    repeat (10) @(posedge clk);
    @(negedge clk); check_reset_state();
    for (int k = 0; k < 2 * S * L + 2; k++) one_period(2, 6);
    // mid-run reset restarts the counts (R1)
    for (int k = 0; k < 4; k++) one_period(2, 6);
    do_reset();
    for (int k = 0; k < 2 * S * L + 1; k++) one_period(25, 30);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule